// File: doc/BRIEF.md
# BF16 Dot-Product Accumulate Unit with FP32 Accumulator

This unit produces one element of D = A·B + C. Each input beat carries eight BF16 elements of A, eight BF16 elements of B and one FP32 accumulator value C. Every BF16 product is formed exactly. The products are then folded into an FP32 running sum one at a time, element 0 first. Each of those additions is rounded to FP32, so precision is never lost in the narrow format. The beat's final FP32 value comes out as D. Because C is an ordinary input, a partial result can be fed back as C to continue a longer reduction, such as a 16-deep tile split over two beats. A separate clear input replaces C with +0 to start a fresh sum.

The operand side is a valid/ready handshake: a beat transfers on a rising edge where `in_valid` and `in_ready` are both high. The result side is a valid/ready stream. A result stays on `out_d` with `out_valid` high until `out_ready` accepts it. While a result is held, the three-stage pipeline freezes and `in_ready` drops, so back-pressure reaches the producer in the same cycle. With `out_ready` held high, the unit accepts one beat per cycle and returns each result exactly three cycles later.

Top module: `mpdot_unit`

## Requirements
- R1: `out_d` equals the sequential FP32 sum C + p0 + p1 + … + p7, with each addition rounded once to FP32 by round-to-nearest-even, where pi = A[i]·B[i] and element i sits in bits [16i+15:16i] of `in_a` and `in_b`.
- R2: A BF16 element is read as sign in bit 15, biased exponent (bias 127) in bits 14:7 and fraction in bits 6:0. Each product is exact before it is added.
- R3: Additions that a BF16 sum would lose, such as 1.0 plus eight terms of 2^-8, are kept to full FP32 precision.
- R4: When `in_clear` is high during a beat, the value on `in_c` is ignored and +0 is used as C.
- R5: A BF16 element with exponent field 0, and a C value with exponent field 0, both count as zero.
- R6: A NaN operand, infinity times zero, or infinities of opposite sign meeting in a sum give the canonical NaN 0x7FC00000.
- R7: An infinite operand gives an infinity of the IEEE sign. A rounded sum whose magnitude reaches 2^128 gives an infinity.
- R8: Any zero result, and any rounded result whose magnitude is below 2^-126, is output as 0x00000000. Negative zero and subnormals never appear.
- R9: With `out_ready` high, `out_valid` rises exactly three cycles after the edge that accepted the beat.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_d` holds. Every accepted beat yields exactly one result, and results leave in the order their beats were accepted.
- R11: During and straight after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_a | input | 128 | Eight BF16 elements of A |
| in_b | input | 128 | Eight BF16 elements of B |
| in_c | input | 32 | FP32 accumulator input C |
| in_clear | input | 1 | Use +0 in place of C for this beat |
| out_valid | output | 1 | Result present on out_d |
| out_ready | input | 1 | Consumer takes the result |
| out_d | output | 32 | FP32 result D |

## Verification
Two functions can fall in the same cycle: a new beat wants to enter while a finished result is being held back, and the result stream either drains or stalls. The bench provokes this by dropping `out_ready` at random while it offers beats with random gaps. Its reference model judges the outcome: `in_ready` must be low whenever a result is held, the held word must not change, and the results must come out in order, each matching the widen-multiply, round-per-add value with none lost and none repeated. A second collision arises inside a single beat, when a special value (NaN, infinity, or an underflowing or overflowing partial sum) meets ordinary terms in the same reduction. Directed beats place these at chosen element positions.

// File: rtl/mpdot_pkg.sv
`timescale 1ns/1ps
package mpdot_pkg;

  localparam int BF_W = 16;
  localparam logic [31:0] CANON_NAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {K_ZERO, K_NUM, K_INF, K_NAN} kind_t;

  // Unpacked-in-meaning FP value: unbiased exponent, 24-bit significand with hidden one at bit 23
  typedef struct packed {
    kind_t              kind;
    logic               sign;
    logic signed [10:0] exp;
    logic [23:0]        sig;
  } xval_t;

  function automatic xval_t bf16_decode(input logic [15:0] x);
    xval_t r;
    r = '0;
    r.sign = x[15];
    if (x[14:7] == 8'd0)        r.kind = K_ZERO;
    else if (x[14:7] == 8'hFF)  r.kind = (x[6:0] != 7'd0) ? K_NAN : K_INF;
    else begin
      r.kind = K_NUM;
      r.exp  = 11'(signed'({3'b000, x[14:7]})) - 11'sd127;
      r.sig  = {1'b1, x[6:0], 16'd0};
    end
    return r;
  endfunction

  function automatic xval_t fp32_decode(input logic [31:0] x);
    xval_t r;
    r = '0;
    r.sign = x[31];
    if (x[30:23] == 8'd0)       r.kind = K_ZERO;
    else if (x[30:23] == 8'hFF) r.kind = (x[22:0] != 23'd0) ? K_NAN : K_INF;
    else begin
      r.kind = K_NUM;
      r.exp  = 11'(signed'({3'b000, x[30:23]})) - 11'sd127;
      r.sig  = {1'b1, x[22:0]};
    end
    return r;
  endfunction

  // Exact product of two decoded BF16 values
  function automatic xval_t fp_mul(input xval_t a, input xval_t b);
    xval_t r;
    logic [15:0] p;
    logic signed [12:0] e;
    r = '0;
    r.sign = a.sign ^ b.sign;
    if (a.kind == K_NAN || b.kind == K_NAN) r.kind = K_NAN;
    else if (a.kind == K_INF || b.kind == K_INF)
      r.kind = (a.kind == K_ZERO || b.kind == K_ZERO) ? K_NAN : K_INF;
    else if (a.kind == K_ZERO || b.kind == K_ZERO) r.kind = K_ZERO;
    else begin
      p = 16'(a.sig[23:16]) * 16'(b.sig[23:16]);
      e = 13'(a.exp) + 13'(b.exp);
      r.kind = K_NUM;
      if (p[15]) begin
        r.sig = {p, 8'd0};
        e     = e + 13'sd1;
      end else begin
        r.sig = {p[14:0], 9'd0};
      end
      r.exp = e[10:0];
    end
    return r;
  endfunction

  // Add with a single round-to-nearest-even to FP32, range check after rounding
  function automatic xval_t fp_add(input xval_t x, input xval_t y);
    xval_t r;
    logic signed [12:0] ex, ey, be, se, d, er;
    logic [23:0] sx, sy, bsig, ssig;
    logic bsgn, ssgn, up;
    logic [26:0] a27, b27, n27;
    logic [53:0] full;
    logic [27:0] s28;
    logic [24:0] m25;
    int lz;
    r = '0;
    r.kind = K_ZERO;
    if (x.kind == K_NAN || y.kind == K_NAN) r.kind = K_NAN;
    else if (x.kind == K_INF && y.kind == K_INF) begin
      if (x.sign != y.sign) r.kind = K_NAN;
      else r = x;
    end
    else if (x.kind == K_INF) r = x;
    else if (y.kind == K_INF) r = y;
    else begin
      ex = (x.kind == K_ZERO) ? -13'sd2048 : 13'(x.exp);
      ey = (y.kind == K_ZERO) ? -13'sd2048 : 13'(y.exp);
      sx = (x.kind == K_ZERO) ? 24'd0 : x.sig;
      sy = (y.kind == K_ZERO) ? 24'd0 : y.sig;
      if ((ex > ey) || (ex == ey && sx >= sy)) begin
        be = ex; bsig = sx; bsgn = x.sign; se = ey; ssig = sy; ssgn = y.sign;
      end else begin
        be = ey; bsig = sy; bsgn = y.sign; se = ex; ssig = sx; ssgn = x.sign;
      end
      d   = be - se;
      a27 = {bsig, 3'b000};
      if (d >= 13'sd27) begin
        b27 = (ssig != 24'd0) ? 27'd1 : 27'd0;
      end else begin
        full = {ssig, 3'b000, 27'd0} >> d[4:0];
        b27  = full[53:27] | {26'd0, |full[26:0]};
      end
      er = be;
      if (bsgn == ssgn) begin
        s28 = {1'b0, a27} + {1'b0, b27};
        if (s28[27]) begin
          n27 = {s28[27:2], s28[1] | s28[0]};
          er  = er + 13'sd1;
        end else begin
          n27 = s28[26:0];
        end
      end else begin
        s28 = {1'b0, a27} - {1'b0, b27};
        n27 = s28[26:0];
        lz  = 0;
        for (int i = 0; i < 27; i++) if (n27[i]) lz = 26 - i;
        n27 = n27 << lz;
        er  = er - 13'(lz);
      end
      if (n27 != 27'd0) begin
        up  = n27[2] & (n27[1] | n27[0] | n27[3]);
        m25 = {1'b0, n27[26:3]} + {24'd0, up};
        if (m25[24]) begin
          m25 = m25 >> 1;
          er  = er + 13'sd1;
        end
        if (er > 13'sd127) begin
          r.kind = K_INF;
          r.sign = bsgn;
        end else if (er >= -13'sd126) begin
          r.kind = K_NUM;
          r.sign = bsgn;
          r.exp  = er[10:0];
          r.sig  = m25[23:0];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] fp_pack(input xval_t v);
    logic signed [10:0] b;
    b = v.exp + 11'sd127;
    case (v.kind)
      K_NUM:   return {v.sign, b[7:0], v.sig[22:0]};
      K_INF:   return {v.sign, 8'hFF, 23'd0};
      K_NAN:   return CANON_NAN;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/mpdot_mul_stage.sv
`timescale 1ns/1ps
module mpdot_mul_stage
  import mpdot_pkg::*;
#(
  parameter int VLEN = 8
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic [VLEN*BF_W-1:0]   a_vec,
  input  logic [VLEN*BF_W-1:0]   b_vec,
  input  logic [31:0]            c_bits,
  input  logic                   clear,
  output xval_t                  prod_q [VLEN],
  output xval_t                  acc_q
);

  xval_t prod_d [VLEN];
  xval_t acc_d;

  for (genvar g = 0; g < VLEN; g++) begin : g_lane
    assign prod_d[g] = fp_mul(bf16_decode(a_vec[g*BF_W +: BF_W]),
                              bf16_decode(b_vec[g*BF_W +: BF_W]));
  end

  always_comb begin
    acc_d = '0;
    acc_d.kind = K_ZERO;
    if (!clear) acc_d = fp32_decode(c_bits);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      acc_q <= acc_d;
      for (int i = 0; i < VLEN; i++) prod_q[i] <= prod_d[i];
    end
  end

endmodule

// File: rtl/mpdot_acc_stage.sv
`timescale 1ns/1ps
module mpdot_acc_stage
  import mpdot_pkg::*;
#(
  parameter int COUNT = 4
) (
  input  logic  clk,
  input  logic  en,
  input  xval_t acc_in,
  input  xval_t prod_in [COUNT],
  output xval_t acc_q
);

  xval_t acc_d;

  // Products are folded in index order; each step rounds to FP32
  always_comb begin
    xval_t t;
    t = acc_in;
    for (int i = 0; i < COUNT; i++) t = fp_add(t, prod_in[i]);
    acc_d = t;
  end

  always_ff @(posedge clk) begin
    if (en) acc_q <= acc_d;
  end

endmodule

// File: rtl/mpdot_unit.sv
`timescale 1ns/1ps
module mpdot_unit
  import mpdot_pkg::*;
#(
  parameter int VLEN = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [VLEN*BF_W-1:0]  in_a,
  input  logic [VLEN*BF_W-1:0]  in_b,
  input  logic [31:0]           in_c,
  input  logic                  in_clear,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [31:0]           out_d
);

  localparam int LO_N = VLEN / 2;
  localparam int HI_N = VLEN - LO_N;

  logic  en;
  logic  v1, v2, v3;
  xval_t prod_s1 [VLEN];
  xval_t acc_s1, acc_s2, acc_s3;
  xval_t lo_s1 [LO_N];
  xval_t hi_s2 [HI_N];

  // Whole pipeline advances together; stalls only when a held result is not taken
  assign en       = !v3 || out_ready;
  assign in_ready = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  mpdot_mul_stage #(.VLEN(VLEN)) u_mul (
    .clk    (clk),
    .en     (en),
    .a_vec  (in_a),
    .b_vec  (in_b),
    .c_bits (in_c),
    .clear  (in_clear),
    .prod_q (prod_s1),
    .acc_q  (acc_s1)
  );

  for (genvar g = 0; g < LO_N; g++) begin : g_lo
    assign lo_s1[g] = prod_s1[g];
  end

  always_ff @(posedge clk) begin
    if (en) for (int i = 0; i < HI_N; i++) hi_s2[i] <= prod_s1[LO_N + i];
  end

  mpdot_acc_stage #(.COUNT(LO_N)) u_acc_lo (
    .clk     (clk),
    .en      (en),
    .acc_in  (acc_s1),
    .prod_in (lo_s1),
    .acc_q   (acc_s2)
  );

  mpdot_acc_stage #(.COUNT(HI_N)) u_acc_hi (
    .clk     (clk),
    .en      (en),
    .acc_in  (acc_s2),
    .prod_in (hi_s2),
    .acc_q   (acc_s3)
  );

  assign out_valid = v3;
  assign out_d     = fp_pack(acc_s3);

endmodule

// File: rtl/mpdot_checker.sv
`timescale 1ns/1ps
module mpdot_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_d
);

  assert_reset_idle_R11: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_d)));

  assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  assert_canonical_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_d[30:23] == 8'hFF && out_d[22:0] != 23'd0) |-> (out_d == 32'h7FC0_0000));

  assert_no_subnormal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_d[30:23] == 8'd0) |-> (out_d == 32'd0));

endmodule

bind mpdot_unit mpdot_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_d     (out_d)
);

// File: tb/tb_mpdot_unit.sv
`timescale 1ns/1ps
module tb_mpdot_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic [31:0]  in_c = '0;
  logic         in_clear = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_d;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    fire_s = 0;
  bit    bp_on = 0;
  bit    done = 0;
  bit    hold_pend = 0;
  logic [31:0] hold_d;
  string cur_tag = "R1";
  bit    cur_lat = 1;

  typedef struct {
    logic [31:0] d;
    int          cyc;
    bit          lat;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  mpdot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_clear(in_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_d(out_d)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // ---------------- reference model: exact integers scaled by 2^300 ----------------
  function automatic logic [31:0] m_round(input bit s, input logic [599:0] mag);
    int p, sh, be;
    logic [599:0] qv, rem, half;
    p = -1;
    for (int i = 0; i < 600; i++) if (mag[i]) p = i;
    if (p < 24) return 32'd0;
    sh   = p - 23;
    qv   = mag >> sh;
    rem  = mag & ((600'd1 << sh) - 600'd1);
    half = 600'd1 << (sh - 1);
    if (rem > half || (rem == half && qv[0])) qv = qv + 600'd1;
    if (qv[24]) begin qv = qv >> 1; p++; end
    be = p - 300 + 127;
    if (be >= 255) return {s, 8'hFF, 23'd0};
    if (be <= 0) return 32'd0;
    return {s, 8'(be), qv[22:0]};
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] acc, input logic [15:0] x, input logic [15:0] y);
    int ae, xe, ye;
    bit a_nan, a_inf, a_zero, x_nan, x_inf, x_zero, y_nan, y_inf, y_zero, p_nan, p_inf, p_zero, ps, s;
    logic [15:0]  pp;
    logic [599:0] accm, pm, mag;
    ae = int'(acc[30:23]); xe = int'(x[14:7]); ye = int'(y[14:7]);
    a_nan = (ae == 255) && (acc[22:0] != 0); a_inf = (ae == 255) && (acc[22:0] == 0); a_zero = (ae == 0);
    x_nan = (xe == 255) && (x[6:0] != 0); x_inf = (xe == 255) && (x[6:0] == 0); x_zero = (xe == 0);
    y_nan = (ye == 255) && (y[6:0] != 0); y_inf = (ye == 255) && (y[6:0] == 0); y_zero = (ye == 0);
    p_nan  = x_nan || y_nan || (x_inf && y_zero) || (y_inf && x_zero);
    p_inf  = x_inf || y_inf;
    p_zero = x_zero || y_zero;
    ps = x[15] ^ y[15];
    if (a_nan || p_nan) return 32'h7FC0_0000;
    if (a_inf && p_inf) return (acc[31] != ps) ? 32'h7FC0_0000 : acc;
    if (a_inf) return acc;
    if (p_inf) return {ps, 8'hFF, 23'd0};
    accm = a_zero ? '0 : (600'({1'b1, acc[22:0]}) << (ae + 150));
    pp   = 16'({1'b1, x[6:0]}) * 16'({1'b1, y[6:0]});
    pm   = p_zero ? '0 : (600'(pp) << (xe + ye + 32));
    if (acc[31] == ps) begin mag = accm + pm; s = ps; end
    else if (accm >= pm) begin mag = accm - pm; s = acc[31]; end
    else begin mag = pm - accm; s = ps; end
    return m_round(s, mag);
  endfunction

  function automatic logic [31:0] ref_dot(input logic [127:0] a, input logic [127:0] b,
                                          input logic [31:0] c, input logic clr);
    logic [31:0] acc;
    acc = clr ? 32'd0 : c;
    if (acc[30:23] == 8'd0) acc = 32'd0;
    for (int i = 0; i < 8; i++) acc = m_step(acc, a[16*i +: 16], b[16*i +: 16]);
    return acc;
  endfunction

  // ---------------- monitor: samples 0.5 ns before each rising edge ----------------
  initial begin
    forever begin
      @(negedge clk);
      #2;
      cyc++;
      fire_s = rst_n && in_valid && in_ready;
      if (rst_n) begin
        if (hold_pend) chk(out_valid && out_d == hold_d, "R10 held result", out_d, hold_d);
        hold_pend = 0;
        if (out_valid) begin
          if (q.size() == 0) chk(0, "R10 extra result", out_d, 32'd0);
          else if (out_ready) begin
            exp_t e;
            e = q.pop_front();
            chk(out_d == e.d, e.tag, out_d, e.d);
            if (e.lat) chk(cyc - e.cyc == 3, "R9 latency", 32'(cyc - e.cyc), 32'd3);
          end else begin
            chk(!in_ready, "R10 ready under stall", {31'd0, in_ready}, 32'd0);
            hold_pend = 1;
            hold_d = out_d;
          end
        end
        if (fire_s) q.push_back('{ref_dot(in_a, in_b, in_c, in_clear), cyc, cur_lat, cur_tag});
      end
    end
  end

  always @(negedge clk) if (bp_on) out_ready = (($urandom % 3) != 0);

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [31:0] c,
                      input logic clr, input string tag, input bit lat);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_clear = clr;
    cur_tag = tag; cur_lat = lat;
    do @(posedge clk); while (!fire_s);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  function automatic logic [15:0] rnd_bf16();
    return {1'($urandom), 8'(120 + ($urandom % 15)), 7'($urandom)};
  endfunction

  function automatic logic [127:0] rnd_vec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = rnd_bf16();
    return v;
  endfunction

  function automatic logic [31:0] rnd_fp32();
    return {1'($urandom), 8'(110 + ($urandom % 30)), 23'($urandom)};
  endfunction

  function automatic logic [127:0] fill(input logic [15:0] x);
    return {8{x}};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    #2;
    chk(!out_valid, "R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!out_valid && in_ready, "R11 idle after reset", {30'd0, out_valid, in_ready}, 32'd1);

    // R2: 1.5 * 2.0 eight times = 24.0, and the negated form
    send(fill(16'h3FC0), fill(16'h4000), 32'd0, 1'b0, "R2 field decode", 1);
    send(fill(16'hBFC0), fill(16'h4000), 32'd0, 1'b0, "R2 negative sign", 1);
    idle(6);
    // R1: random back-to-back beats
    for (int i = 0; i < 30; i++) send(rnd_vec(), rnd_vec(), rnd_fp32(), 1'b0, "R1 random", 1);
    // R1: ties to even: 1.0 + 2^-24 stays 1.0; (1+2^-23) + 2^-24 rounds up
    send({112'd0, 16'h3380}, {112'd0, 16'h3F80}, 32'h3F80_0000, 1'b0, "R1 tie even down", 1);
    send({112'd0, 16'h3380}, {112'd0, 16'h3F80}, 32'h3F80_0001, 1'b0, "R1 tie odd up", 1);
    // R3: 1.0 + 8 * 2^-8 kept in FP32
    send(fill(16'h3B80), fill(16'h3F80), 32'h3F80_0000, 1'b0, "R3 fp32 accumulate", 1);
    // R4: clear overrides C
    a = rnd_vec(); b = rnd_vec();
    send(a, b, 32'h4B00_0000, 1'b1, "R4 clear ignores C", 1);
    send(fill(16'h3F80), fill(16'h3F80), 32'hC2C8_0000, 1'b1, "R4 clear gives 8.0", 1);
    // R5: subnormal operands and C
    send(fill(16'h0001), fill(16'h3F80), 32'h0000_0005, 1'b0, "R5 subnormal flush", 1);
    a = rnd_vec(); a[15:0] = 16'h0040;
    send(a, {rnd_vec()} | 128'h7F00, 32'h8000_0003, 1'b0, "R5 mixed subnormal", 1);
    // R6: NaN cases
    a = rnd_vec(); a[63:48] = 16'h7FC1;
    send(a, rnd_vec(), rnd_fp32(), 1'b0, "R6 nan operand", 1);
    a = rnd_vec(); b = rnd_vec(); a[31:16] = 16'h7F80; b[31:16] = 16'h0000;
    send(a, b, rnd_fp32(), 1'b0, "R6 inf times zero", 1);
    a = rnd_vec(); b = rnd_vec(); a[15:0] = 16'h7F80; b[15:0] = 16'h3F80;
    a[95:80] = 16'hFF80; b[95:80] = 16'h3F80;
    send(a, b, rnd_fp32(), 1'b0, "R6 inf minus inf", 1);
    // R7: infinity and overflow
    a = rnd_vec(); a[15:0] = 16'hFF80; b = rnd_vec(); b[15:0] = 16'h3F80;
    send(a, b, rnd_fp32(), 1'b0, "R7 inf operand", 1);
    send({112'd0, 16'h7F00}, {112'd0, 16'h7F00}, 32'd0, 1'b0, "R7 overflow", 1);
    // R8: underflow and exact cancellation
    send(fill(16'h0080), fill(16'h0080), 32'd0, 1'b0, "R8 underflow", 1);
    send({112'd0, 16'hBF80}, {112'd0, 16'h3F80}, 32'h3F80_0000, 1'b0, "R8 cancel to +0", 1);
    send({112'd0, 16'h8080}, {112'd0, 16'h0080}, 32'd0, 1'b0, "R8 negative tiny", 1);
    idle(8);
    // R10: random back-pressure with gaps
    bp_on = 1;
    for (int i = 0; i < 40; i++) begin
      send(rnd_vec(), rnd_vec(), rnd_fp32(), 1'($urandom % 4 == 0), "R10 backpressure", 0);
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end
    idle(2);
    bp_on = 0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk(q.size() == 0, "R10 all results delivered", 32'(q.size()), 32'd0);
    done = 1;
    finish_run();
  end

endmodule